// File: doc/BRIEF.md
# Pause Frame Transmit Inserter

This block sits in front of an Ethernet MAC transmit path and merges software-requested flow-control pause frames into the outgoing byte stream. Normal frames arrive on a byte-wide valid/ready stream and are passed through unchanged. A single register write asks for a pause frame and carries the 16-bit pause time. The block holds that request and builds the whole pause frame itself, padded to minimum size. The frame goes out either at once, when the transmitter is idle, or right after the normal frame that is in flight. CRC is appended by a later stage.

Every transmitted block, normal or pause, is followed by a fixed idle gap. While a pause frame and its gap are being sent, the normal stream is stalled. There are two completion status bits, one for normal frames and one for pause frames. Each is cleared by writing a 1 to it. A mask selects which status bits drive the interrupt output.

Register writes use `reg_sel`: 0 selects the pause request, 1 selects the status clear and 2 selects the mask. For the request, `reg_wdata[16]` is the request flag and `reg_wdata[15:0]` is the pause time. Status and mask bit 0 belong to normal-frame completion and bit 1 to pause-frame completion.

Top module: `pause_tx_merge`

## Requirements
- R1: A write with `reg_sel`=0 and `reg_wdata[16]`=1 arms a pending pause request and stores `reg_wdata[15:0]` as the pause time. The same write with bit 16 clear arms nothing, and no frame follows.
- R2: A pause frame is 60 bytes, sent in this order: the bytes 01 80 C2 00 00 01; `src_mac` with its most significant byte first; 88 08; 00 01; the pause time with its high byte first; then 42 zero bytes.
- R3: A pending request is sent only while `cfg_flow`, `cfg_fd` and `cfg_txen` are all 1. While any of them is 0, the request stays pending, and it goes out once all three are 1.
- R4: When a write arms an eligible request while the block is idle and past its gap, the first pause byte is on `out_data`, with `out_en` high, on the second rising edge after the write edge.
- R5: A request that arrives during a normal frame leaves that frame's bytes and length unchanged. The pause frame is the next block to go out.
- R6: Consecutive blocks are separated by at least 12 cycles with `out_en` low. When the next block is already waiting, the gap is exactly 12 cycles.
- R7: `in_ready` is low while a pause frame or any gap is in progress. It is high when the block is idle with no eligible request, and during a normal frame.
- R8: `status[0]` sets when the last byte of a normal frame is accepted, and `status[1]` sets when the last pause byte is sent. Both can be set at once, and both are 0 after reset.
- R9: A status bit clears only when a write with `reg_sel`=1 has a 1 in its position. A 0 in that position leaves the bit unchanged.
- R10: `irq` is one clock behind the OR of (status AND mask). A set status bit whose mask bit is 0 leaves `irq` low, and the status bit still reads as set.
- R11: A new request written while one is pending replaces the stored pause time, and only one pause frame is sent.
- R12: When an eligible request and a waiting normal frame both find the block idle, the pause frame goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_txen | input | 1 | Transmitter enabled |
| cfg_fd | input | 1 | Full-duplex mode |
| cfg_flow | input | 1 | Transmit flow control enabled |
| src_mac | input | 48 | Source address placed in pause frames |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 request, 1 status clear, 2 mask |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Normal stream byte valid (held high from first to last byte) |
| in_data | input | 8 | Normal stream byte |
| in_last | input | 1 | Last byte of a normal frame |
| in_ready | output | 1 | Normal stream may advance |
| out_en | output | 1 | Transmit enable |
| out_data | output | 8 | Transmit byte |
| status | output | 2 | Completion status: bit 0 normal, bit 1 pause |
| irq | output | 1 | Interrupt |

## Verification
A wrong pending flag or a stuck state shows up on the ports. Either no frame appears after a request, or a second, unexpected pause block appears, or `in_ready` stays low and blocks the normal source. The block counter and the gap counter fail in visible ways. A miscounted byte index changes the length or the content of a 60-byte pause block within one frame time. A gap timer that is off by one shifts the next `out_en` rise by a cycle against the fixed 12-cycle spacing. Faults in the status and mask registers reach `irq` one cycle after the status changes. They can therefore be seen within a few cycles of each completion or register write.

// File: rtl/pftx_pkg.sv
package pftx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_NORM, ST_PAUSE, ST_GAP} st_e;

  localparam logic [1:0] SEL_REQ  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;
  localparam int         REQ_BIT  = 16;

  localparam logic [47:0] CTRL_DA   = 48'h0180C2000001;
  localparam logic [15:0] CTRL_TYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPC = 16'h0001;
  localparam int          HDR_BYTES = 14;
endpackage

// File: rtl/pftx_frame_byte.sv
module pftx_frame_byte #(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [47:0]      src,
  input  logic [15:0]      pause_val,
  output logic [7:0]       byte_o
);
  import pftx_pkg::*;

  int i;
  always_comb begin
    i = int'(idx);
    if (i < 6)
      byte_o = 8'(CTRL_DA >> (8 * (5 - i)));
    else if (i < 12)
      byte_o = 8'(src >> (8 * (11 - i)));
    else begin
      case (i)
        12:      byte_o = CTRL_TYPE[15:8];
        13:      byte_o = CTRL_TYPE[7:0];
        14:      byte_o = PAUSE_OPC[15:8];
        15:      byte_o = PAUSE_OPC[7:0];
        16:      byte_o = pause_val[15:8];
        17:      byte_o = pause_val[7:0];
        default: byte_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/pftx_irq.sv
module pftx_irq #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_vec,
  input  logic          clr_we,
  input  logic [NB-1:0] clr_vec,
  input  logic          mask_we,
  input  logic [NB-1:0] mask_vec,
  output logic [NB-1:0] status_q,
  output logic [NB-1:0] mask_q,
  output logic          irq_q
);
  logic [NB-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_vec : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_eff) | set_vec;
      if (mask_we) mask_q <= mask_vec;
      irq_q <= |(status_q & mask_q);
    end
  end
endmodule

// File: rtl/pause_tx_merge.sv
module pause_tx_merge #(
  parameter int MIN_PAYLOAD = 46,
  parameter int GAP_BYTES   = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_txen,
  input  logic        cfg_fd,
  input  logic        cfg_flow,
  input  logic [47:0] src_mac,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        out_en,
  output logic [7:0]  out_data,
  output logic [1:0]  status,
  output logic        irq
);
  import pftx_pkg::*;

  localparam int FRAME_BYTES = HDR_BYTES + MIN_PAYLOAD;
  localparam int CW = $clog2(FRAME_BYTES);
  localparam int GW = $clog2(GAP_BYTES);
  localparam logic [CW-1:0] C_LAST = CW'(FRAME_BYTES - 1);
  localparam logic [GW-1:0] G_LAST = GW'(GAP_BYTES - 1);

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic [GW-1:0] gcnt_q;
  logic          pend_q;
  logic [15:0]   val_q;
  logic [15:0]   shadow_q;
  logic [7:0]    gen_byte;
  logic [1:0]    mask_w;
  logic          elig, req_wr, take;
  logic [1:0]    set_vec;

  assign elig     = pend_q & cfg_flow & cfg_fd & cfg_txen;
  assign req_wr   = reg_we && (reg_sel == SEL_REQ) && reg_wdata[REQ_BIT];
  assign in_ready = ((st_q == ST_IDLE) && !elig) || (st_q == ST_NORM);
  assign take     = in_valid && in_ready;
  assign set_vec  = {(st_q == ST_PAUSE) && (cnt_q == C_LAST), take && in_last};

  pftx_frame_byte #(.IDX_W(CW)) u_gen (
    .idx       (cnt_q),
    .src       (src_mac),
    .pause_val (shadow_q),
    .byte_o    (gen_byte)
  );

  pftx_irq #(.NB(2)) u_sts (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_we   (reg_we && (reg_sel == SEL_STAT)),
    .clr_vec  (reg_wdata[1:0]),
    .mask_we  (reg_we && (reg_sel == SEL_MASK)),
    .mask_vec (reg_wdata[1:0]),
    .status_q (status),
    .mask_q   (mask_w),
    .irq_q    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      gcnt_q   <= '0;
      pend_q   <= 1'b0;
      val_q    <= '0;
      shadow_q <= '0;
      out_en   <= 1'b0;
      out_data <= '0;
    end else begin
      out_en <= 1'b0;
      if (req_wr) begin
        pend_q <= 1'b1;
        val_q  <= reg_wdata[15:0];
      end
      case (st_q)
        ST_IDLE: begin
          if (elig) begin
            if (!req_wr) pend_q <= 1'b0;
            shadow_q <= val_q;
            out_en   <= 1'b1;
            out_data <= gen_byte;
            cnt_q    <= CW'(1);
            st_q     <= ST_PAUSE;
          end else if (take) begin
            out_en   <= 1'b1;
            out_data <= in_data;
            gcnt_q   <= '0;
            st_q     <= in_last ? ST_GAP : ST_NORM;
          end
        end
        ST_NORM: begin
          if (in_valid) begin
            out_en   <= 1'b1;
            out_data <= in_data;
            if (in_last) begin
              gcnt_q <= '0;
              st_q   <= ST_GAP;
            end
          end
        end
        ST_PAUSE: begin
          out_en   <= 1'b1;
          out_data <= gen_byte;
          if (cnt_q == C_LAST) begin
            cnt_q  <= '0;
            gcnt_q <= '0;
            st_q   <= ST_GAP;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: begin
          if (gcnt_q == G_LAST) st_q <= ST_IDLE;
          else gcnt_q <= gcnt_q + GW'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/pftx_checker.sv
module pftx_checker #(
  parameter int GAP_BYTES = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_txen,
  input logic             cfg_fd,
  input logic             cfg_flow,
  input logic             reg_we,
  input logic [1:0]       reg_sel,
  input logic [31:0]      reg_wdata,
  input logic             in_ready,
  input logic             out_en,
  input logic [1:0]       status,
  input logic [1:0]       mask,
  input logic             irq,
  input pftx_pkg::st_e    st
);
  import pftx_pkg::*;

  logic        prev_oe, gap_prev, armed;
  logic [15:0] lowc;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_oe  <= 1'b0;
      gap_prev <= 1'b0;
      armed    <= 1'b0;
      lowc     <= '0;
    end else begin
      prev_oe  <= out_en;
      gap_prev <= (st == ST_GAP);
      if ((st == ST_GAP) && !gap_prev) begin
        armed <= 1'b1;
        lowc  <= '0;
      end else begin
        if (!out_en && (lowc != 16'hFFFF)) lowc <= lowc + 16'd1;
        if (out_en && !prev_oe) armed <= 1'b0;
      end
    end
  end

  assert_gated_start_R3: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_PAUSE) && ($past(st) != ST_PAUSE)) |-> $past(cfg_flow && cfg_fd && cfg_txen));

  assert_pause_holds_input_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PAUSE) |-> (out_en && !in_ready));

  assert_min_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (out_en && !prev_oe && armed) |-> (lowc >= 16'(GAP_BYTES)));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(status & mask)));

  assert_w1c_bit0_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(status[0]) |-> $past(reg_we && (reg_sel == SEL_STAT) && reg_wdata[0]));

  assert_w1c_bit1_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(status[1]) |-> $past(reg_we && (reg_sel == SEL_STAT) && reg_wdata[1]));
endmodule

bind pause_tx_merge pftx_checker #(.GAP_BYTES(GAP_BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_txen  (cfg_txen),
  .cfg_fd    (cfg_fd),
  .cfg_flow  (cfg_flow),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .in_ready  (in_ready),
  .out_en    (out_en),
  .status    (status),
  .mask      (mask_w),
  .irq       (irq),
  .st        (st_q)
);

// File: tb/pause_tx_merge_tb.sv
module pause_tx_merge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_txen = 1'b1, cfg_fd = 1'b1, cfg_flow = 1'b1;
  logic [47:0] src_mac = 48'h021122334455;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_en, irq;
  logic [7:0]  out_data;
  logic [1:0]  status;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  pause_tx_merge u_dut (
    .clk(clk), .rst(rst), .cfg_txen(cfg_txen), .cfg_fd(cfg_fd), .cfg_flow(cfg_flow),
    .src_mac(src_mac), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_en(out_en), .out_data(out_data), .status(status), .irq(irq)
  );

  // Output monitor: splits the out_en stream into blocks and records gaps.
  logic [7:0] cap [0:8191];
  int blk_start [0:127];
  int blk_len   [0:127];
  int blk_gap   [0:127];
  int nbytes = 0, nblk = 0, lowcnt = 0;
  logic prev_oe = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_en) begin
        if (!prev_oe && nblk < 128) begin
          blk_start[nblk] = nbytes;
          blk_len[nblk]   = 0;
          blk_gap[nblk]   = lowcnt;
          nblk = nblk + 1;
        end
        if (nbytes < 8192) begin
          cap[nbytes] = out_data;
          nbytes = nbytes + 1;
        end
        if (nblk > 0) blk_len[nblk-1] = blk_len[nblk-1] + 1;
        lowcnt = 0;
      end else begin
        lowcnt = lowcnt + 1;
      end
      prev_oe = out_en;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pbyte(input int i, input logic [47:0] s, input logic [15:0] v);
    logic [7:0] hdr [0:17];
    hdr[0] = 8'h01; hdr[1] = 8'h80; hdr[2] = 8'hC2; hdr[3] = 8'h00; hdr[4] = 8'h00; hdr[5] = 8'h01;
    for (int k = 0; k < 6; k++) hdr[6+k] = s[47-8*k -: 8];
    hdr[12] = 8'h88; hdr[13] = 8'h08; hdr[14] = 8'h00; hdr[15] = 8'h01;
    hdr[16] = v[15:8]; hdr[17] = v[7:0];
    return (i < 18) ? hdr[i] : 8'h00;
  endfunction

  function automatic logic [7:0] nbyte(input int seed, input int i);
    return 8'(seed + i * 7);
  endfunction

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input int len, input int seed);
    int i = 0;
    bit r;
    while (i < len) begin
      @(negedge clk); #1;
      in_valid = 1'b1; in_data = nbyte(seed, i); in_last = (i == len - 1);
      r = in_ready;
      @(posedge clk);
      if (r) i++;
    end
    #1 in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic chk_pause(input int b, input logic [47:0] s, input logic [15:0] v, input string tag);
    int bad = 0;
    chk(b < nblk, {tag, " pause block present"}, nblk, b + 1);
    if (b < nblk) begin
      chk(blk_len[b] == 60, {tag, " pause length"}, blk_len[b], 60);
      for (int k = 0; k < 60 && k < blk_len[b]; k++)
        if (cap[blk_start[b] + k] !== exp_pbyte(k, s, v)) begin
          if (bad == 0)
            chk(1'b0, {tag, " pause byte"}, cap[blk_start[b] + k], exp_pbyte(k, s, v));
          bad++;
        end
      if (bad == 0) chk(1'b1, tag, 0, 0);
    end
  endtask

  task automatic chk_norm(input int b, input int len, input int seed, input string tag);
    int bad = 0;
    chk(b < nblk, {tag, " normal block present"}, nblk, b + 1);
    if (b < nblk) begin
      chk(blk_len[b] == len, {tag, " normal length"}, blk_len[b], len);
      for (int k = 0; k < len && k < blk_len[b]; k++)
        if (cap[blk_start[b] + k] !== nbyte(seed, k)) begin
          if (bad == 0)
            chk(1'b0, {tag, " normal byte"}, cap[blk_start[b] + k], nbyte(seed, k));
          bad++;
        end
      if (bad == 0) chk(1'b1, tag, 0, 0);
    end
  endtask

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    logic [15:0] vals [0:3];
    logic [47:0] srcs [0:3];
    vals[0] = 16'h0000; vals[1] = 16'hFFFF; vals[2] = 16'h00FF; vals[3] = 16'h8001;
    srcs[0] = 48'hFFFFFFFFFFFF; srcs[1] = 48'h000000000000; srcs[2] = 48'hA5A55A5A0F0F; srcs[3] = 48'h123456789ABC;

    idle(4);
    @(negedge clk) rst = 1'b0;
    idle(1);
    // Reset state: R8 status, R7 ready, R10 irq
    chk(out_en == 1'b0, "R6 reset out_en", out_en, 0);
    chk(status == 2'b00, "R8 reset status", status, 0);
    chk(irq == 1'b0, "R10 reset irq", irq, 0);
    chk(in_ready == 1'b1, "R7 reset ready", in_ready, 1);

    // R1: flag clear arms nothing
    base = nblk;
    wr_reg(2'd0, 32'h0000_5555);
    idle(30);
    chk(nblk == base, "R1 no request without flag", nblk - base, 0);

    // R4 + R2: idle start, frame content
    base = nblk;
    wr_reg(2'd0, 32'h0001_1234);
    idle(1);
    chk(out_en === 1'b1 && out_data === 8'h01, "R4 idle start latency", {out_en, out_data}, 9'h101);
    idle(80);
    chk_pause(base, src_mac, 16'h1234, "R2 R1 idle pause");
    chk(status == 2'b10, "R8 pause status", status, 2'b10);
    chk(irq == 1'b0, "R10 masked irq low", irq, 0);

    // R10 mask and R9 clear
    wr_reg(2'd2, 32'h2);
    idle(3);
    chk(irq == 1'b1, "R10 unmasked irq", irq, 1);
    wr_reg(2'd1, 32'h0);
    idle(3);
    chk(status == 2'b10, "R9 write zero keeps bit", status, 2'b10);
    wr_reg(2'd1, 32'h2);
    idle(3);
    chk(status == 2'b00, "R9 write one clears", status, 0);
    chk(irq == 1'b0, "R10 irq drops after clear", irq, 0);

    // R3: each enable alone blocks; request stays pending
    for (int e = 0; e < 3; e++) begin
      base = nblk;
      if (e == 0) cfg_fd = 1'b0; else if (e == 1) cfg_flow = 1'b0; else cfg_txen = 1'b0;
      wr_reg(2'd0, 32'h0001_0000 | 32'(16'h1111 * (e + 1)));
      idle(90);
      chk(nblk == base, "R3 gated while disabled", nblk - base, 0);
      cfg_fd = 1'b1; cfg_flow = 1'b1; cfg_txen = 1'b1;
      idle(80);
      chk_pause(base, src_mac, 16'(16'h1111 * (e + 1)), "R3 sent after enable");
    end

    // R11: replacement while pending
    base = nblk;
    cfg_fd = 1'b0;
    wr_reg(2'd0, 32'h0001_1111);
    wr_reg(2'd0, 32'h0001_2222);
    idle(10);
    cfg_fd = 1'b1;
    idle(120);
    chk(nblk - base == 1, "R11 single pause frame", nblk - base, 1);
    chk_pause(base, src_mac, 16'h2222, "R11 replaced value");

    // R5/R6/R7/R8: request during a normal frame
    wr_reg(2'd1, 32'h3);
    base = nblk;
    fork
      send_frame(20, 8'h30);
      begin idle(6); wr_reg(2'd0, 32'h0001_ABCD); end
    join
    idle(20);
    chk(in_ready == 1'b0, "R7 ready low during pause", in_ready, 0);
    idle(80);
    chk(in_ready == 1'b1, "R7 ready released", in_ready, 1);
    chk_norm(base, 20, 8'h30, "R5 normal unchanged");
    chk_pause(base + 1, src_mac, 16'hABCD, "R5 pause follows");
    chk(blk_gap[base + 1] == 12, "R6 gap normal to pause", blk_gap[base + 1], 12);
    chk(status == 2'b11, "R8 both status bits", status, 2'b11);

    // R12: pause wins over waiting normal frame; gaps exact
    base = nblk;
    fork
      begin send_frame(10, 8'h51); send_frame(7, 8'h77); end
      begin idle(3); wr_reg(2'd0, 32'h0001_0F0F); end
    join
    idle(30);
    chk_norm(base, 10, 8'h51, "R12 first normal");
    chk_pause(base + 1, src_mac, 16'h0F0F, "R12 pause before waiting frame");
    chk_norm(base + 2, 7, 8'h77, "R12 waiting frame after pause");
    chk(blk_gap[base + 2] == 12, "R6 gap pause to normal", blk_gap[base + 2], 12);

    // R6 sweep: back-to-back normal frames of lengths 1..6
    base = nblk;
    for (int L = 1; L <= 6; L++) send_frame(L, 8'h10 * L);
    idle(30);
    for (int L = 1; L <= 6; L++) begin
      chk_norm(base + L - 1, L, 8'h10 * L, "R6 sweep frame");
      if (L > 1) chk(blk_gap[base + L - 1] == 12, "R6 sweep gap", blk_gap[base + L - 1], 12);
    end

    // R2 sweep: pause values and source addresses
    for (int k = 0; k < 4; k++) begin
      base = nblk;
      src_mac = srcs[k];
      wr_reg(2'd0, 32'h0001_0000 | 32'(vals[k]));
      idle(80);
      chk_pause(base, srcs[k], vals[k], "R2 sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule